// File: doc/BRIEF.md
# Transmit Idle-Fill Character Inserter

This block sits between a transmit FIFO and the load point of a serializer. Every clock cycle is one character slot. In each slot the block decides what character goes to the line. If the FIFO has a word ready, the block pops it and forwards it unchanged. If the FIFO is empty, the block inserts a sync fill character, so the serializer never runs dry. To send a continuous stream with no fill, the FIFO must be written at least as fast as it is read.

Two character widths are supported, selected by `wide_mode`:

- **10-bit mode** carries pre-encoded words. The fill is the K28.5 comma. The block keeps its own running-disparity toggle for the fill, so successive commas alternate between their negative and positive forms. User words are never counted in that toggle.
- **12-bit mode** uses a fixed sync pattern, set by a parameter, in place of the comma.

The FIFO is assumed to be show-ahead: `fifo_data` is valid whenever `fifo_empty` is low, and the word is consumed in the cycle where `fifo_rd` is high. The outgoing character is registered, so it appears one cycle after its slot decision. A companion flag marks the slots that carry fill.

Top module: `idle_fill_inserter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `char_out` becomes 0 and `fill_active` becomes 0 on that edge. `fifo_rd` is held low during reset. The fill disparity returns to negative.
- R2: Outside reset, `fifo_rd` equals the inverse of `fifo_empty` in the same cycle. The block never reads from an empty FIFO.
- R3: In 10-bit mode (`wide_mode`=0), a slot with `fifo_empty`=0 sets `char_out` on the next edge to `{2'b00, fifo_data[9:0]}`.
- R4: In 12-bit mode (`wide_mode`=1), a slot with `fifo_empty`=0 sets `char_out` on the next edge to all 12 bits of `fifo_data`, unchanged.
- R5: In 10-bit mode, a slot with `fifo_empty`=1 sets `char_out` on the next edge to a K28.5 character. The negative form is 10'b0011111010 and the positive form is 10'b1100000101. Bit 9 is the first bit sent, and bits 11:10 are 0.
- R6: The first 10-bit fill after reset is the negative form. Each further 10-bit fill uses the form opposite to the previous 10-bit fill.
- R7: Data slots do not change which K28.5 form comes next. Neither do 12-bit fills.
- R8: In 12-bit mode, a slot with `fifo_empty`=1 sets `char_out` on the next edge to the parameter `WIDE_FILL`, which defaults to 12'b011000010001.
- R9: `fill_active` goes high on the edge after every slot that had `fifo_empty`=1. It goes low on the edge after every slot that had `fifo_empty`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 0: 10-bit pre-encoded words, 1: 12-bit words |
| fifo_empty | input | 1 | FIFO has no word ready |
| fifo_data | input | CHAR_W | Head word of the show-ahead FIFO |
| fifo_rd | output | 1 | Pop strobe to the FIFO |
| char_out | output | CHAR_W | Character for the serializer, registered |
| fill_active | output | 1 | The character now on `char_out` is inserted fill |

## Verification
The only internal state is the fill-disparity toggle, and it is visible only through the next 10-bit fill. If the toggle is wrong, the line shows two commas of the same polarity in a row, or a first comma of the wrong polarity. This appears one cycle after the next empty slot in 10-bit mode. It can stay hidden through any number of data slots and 12-bit fills. For that reason, the stimulus mixes long data bursts and width switches in between fills. A wrong slot decision shows up at once: `fifo_rd` is wrong combinationally, and `char_out` is wrong on the following edge.

// File: rtl/ifill_pkg.sv
// Package: shared constants and types for the idle-fill inserter.
// Assumes 10-bit codes carry their first serial bit in bit 9.
package ifill_pkg;
    localparam int NARROW_W = 10;

    // K28.5 comma, both running-disparity forms
    localparam logic [NARROW_W-1:0] COMMA_NEG = 10'b0011111010;
    localparam logic [NARROW_W-1:0] COMMA_POS = 10'b1100000101;

    // Running disparity of the next comma to send
    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } disp_t;
endpackage

// File: rtl/ifill_slot_ctrl.sv
// Module: slot controller. Decides per slot whether to pop the FIFO or fill.
// Assumes a show-ahead FIFO whose empty flag is valid every cycle.
module ifill_slot_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    output logic fifo_rd,
    output logic fill_req
);
    // Pop only when a word is present and the block is out of reset
    always_comb begin
        fifo_rd  = rst_n & ~fifo_empty;
        fill_req = fifo_empty;
    end

    p_no_empty_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_rd);
    p_read_when_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |-> fifo_rd);
endmodule

// File: rtl/ifill_fill_gen.sv
// Module: fill generator. Produces the sync fill character and tracks the
// comma's running disparity. Only 10-bit fills advance the toggle.
module ifill_fill_gen
    import ifill_pkg::*;
#(
    parameter int                CHAR_W    = 12,
    parameter logic [CHAR_W-1:0] WIDE_FILL = 12'b011000010001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_req,
    input  logic              wide_mode,
    output logic [CHAR_W-1:0] fill_char
);
    localparam int PAD_W = CHAR_W - NARROW_W;

    disp_t disp_q;
    logic  comma_slot;

    // A comma is sent when a fill is requested in 10-bit mode
    always_comb comma_slot = fill_req & ~wide_mode;

    // Flip the disparity after each comma is sent; start negative
    always_ff @(posedge clk) begin
        if (!rst_n)
            disp_q <= RD_NEG;
        else if (comma_slot)
            disp_q <= (disp_q == RD_NEG) ? RD_POS : RD_NEG;
    end

    // Select the fill: the fixed wide pattern, or the comma in its current form
    always_comb begin
        if (wide_mode)
            fill_char = WIDE_FILL;
        else
            fill_char = {{PAD_W{1'b0}}, (disp_q == RD_NEG) ? COMMA_NEG : COMMA_POS};
    end

    p_comma_alternates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        comma_slot |=> disp_q != $past(disp_q));
    p_disp_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !comma_slot |=> disp_q == $past(disp_q));
endmodule

// File: rtl/ifill_data_fmt.sv
// Module: data formatter. Passes the user word through unchanged at the
// selected width. Unused upper bits are zero in 10-bit mode.
module ifill_data_fmt
    import ifill_pkg::*;
#(
    parameter int CHAR_W = 12
) (
    input  logic [CHAR_W-1:0] fifo_data,
    input  logic              wide_mode,
    output logic [CHAR_W-1:0] data_char
);
    localparam int PAD_W = CHAR_W - NARROW_W;

    logic [CHAR_W-1:0] narrow_char;

    // Zero-extend the 10-bit word, with or without pad bits
    generate
        if (PAD_W > 0) begin : g_pad
            always_comb narrow_char = {{PAD_W{1'b0}}, fifo_data[NARROW_W-1:0]};
        end else begin : g_nopad
            always_comb narrow_char = fifo_data;
        end
    endgenerate

    // Pick the full word or the narrow word by mode
    always_comb data_char = wide_mode ? fifo_data : narrow_char;
endmodule

// File: rtl/idle_fill_inserter.sv
// Module: top of the idle-fill inserter. Each cycle is one character slot.
// A ready word is forwarded; an empty FIFO yields sync fill. The output is
// registered one cycle after the slot decision.
module idle_fill_inserter
    import ifill_pkg::*;
#(
    parameter int                CHAR_W    = 12,
    parameter logic [CHAR_W-1:0] WIDE_FILL = 12'b011000010001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic [CHAR_W-1:0] char_out,
    output logic              fill_active
);
    logic              fill_req;
    logic [CHAR_W-1:0] fill_char;
    logic [CHAR_W-1:0] data_char;

    ifill_slot_ctrl u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_rd    (fifo_rd),
        .fill_req   (fill_req)
    );

    ifill_fill_gen #(
        .CHAR_W    (CHAR_W),
        .WIDE_FILL (WIDE_FILL)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_req  (fill_req),
        .wide_mode (wide_mode),
        .fill_char (fill_char)
    );

    ifill_data_fmt #(
        .CHAR_W (CHAR_W)
    ) u_fmt (
        .fifo_data (fifo_data),
        .wide_mode (wide_mode),
        .data_char (data_char)
    );

    // Register the chosen character and the fill flag for the serializer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_out    <= '0;
            fill_active <= 1'b0;
        end else begin
            char_out    <= fill_req ? fill_char : data_char;
            fill_active <= fill_req;
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (char_out == '0) && !fill_active);
    p_pass_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && !wide_mode) |=>
            char_out == {{(CHAR_W-NARROW_W){1'b0}}, $past(fifo_data[NARROW_W-1:0])});
    p_pass_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && wide_mode) |=> char_out == $past(fifo_data));
    p_comma_sent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && !wide_mode) |=>
            (char_out[NARROW_W-1:0] == COMMA_NEG) || (char_out[NARROW_W-1:0] == COMMA_POS));
    p_wide_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && wide_mode) |=> char_out == WIDE_FILL);
    p_fill_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |=> fill_active);
    p_data_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |=> !fill_active);
endmodule

// File: tb/tb_idle_fill_inserter.sv
// Bench: directed corner cases and seeded random slots. Each output is
// compared against a model written from the requirements.
module tb_idle_fill_inserter;
    localparam int           CW    = 12;
    localparam logic [11:0]  WFILL = 12'b011000010001;
    localparam logic [9:0]   KNEG  = 10'b0011111010;
    localparam logic [9:0]   KPOS  = 10'b1100000101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wide_mode = 1'b0;
    logic          fifo_empty = 1'b1;
    logic [CW-1:0] fifo_data = '0;
    logic          fifo_rd;
    logic [CW-1:0] char_out;
    logic          fill_active;

    int checks = 0;
    int errors = 0;
    bit next_pos = 1'b0;   // model: form of the next comma (0 means negative)
    bit done = 1'b0;

    idle_fill_inserter #(.CHAR_W(CW), .WIDE_FILL(WFILL)) dut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .char_out(char_out), .fill_active(fill_active)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Expected character from the requirements (R3, R4, R5, R6, R8)
    function automatic logic [CW-1:0] exp_char(bit empty, bit wide,
                                               logic [CW-1:0] d, bit pos);
        if (!empty) return wide ? d : {2'b00, d[9:0]};
        if (wide)   return WFILL;
        return {2'b00, pos ? KPOS : KNEG};
    endfunction

    task automatic check(bit ok, string req, logic [CW-1:0] act, logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Run one slot: drive the inputs, check the strobe, then check the registered output
    task automatic slot(bit empty, bit wide, logic [CW-1:0] d);
        logic [CW-1:0] e;
        fifo_empty = empty; wide_mode = wide; fifo_data = d;
        #1;
        check(fifo_rd == !empty, "R2", {11'd0, fifo_rd}, {11'd0, !empty});
        e = exp_char(empty, wide, d, next_pos);
        if (empty && !wide) next_pos = !next_pos;   // R6, R7 model
        @(negedge clk);
        check(char_out == e, empty ? (wide ? "R8" : "R5/R6") : (wide ? "R4" : "R3/R7"),
              char_out, e);
        check(fill_active == empty, "R9", {11'd0, fill_active}, {11'd0, empty});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fifo_empty = 1'b0; fifo_data = 12'hABC;
        @(negedge clk); @(negedge clk);
        check(char_out == '0, "R1", char_out, '0);
        check(!fill_active, "R1", {11'd0, fill_active}, '0);
        check(!fifo_rd, "R1", {11'd0, fifo_rd}, '0);
        rst_n = 1'b1; next_pos = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // R6: first comma after reset is negative, then alternating
        slot(1, 0, '0); slot(1, 0, '0); slot(1, 0, '0);
        // R7: data and 12-bit fills do not move the toggle
        slot(0, 0, 12'hFFF); slot(0, 0, 12'h155);
        slot(1, 1, '0); slot(1, 1, '0);
        slot(1, 0, '0);
        // R4 / R3 width handling of the upper bits
        slot(0, 1, 12'hC03); slot(0, 0, 12'hC03);
        // R1: a mid-run reset returns the comma to negative
        slot(1, 0, '0);
        do_reset();
        slot(1, 0, '0); slot(1, 0, '0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            slot(($urandom % 3) == 0, ($urandom % 4) == 0, CW'($urandom));
        end
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule